// File: doc/BRIEF.md
# Boundary-Pausing Simple DMA Engine

This block moves whole fixed-size blocks between a host memory bus and the data stream of a card host controller. Software first loads a start address, a block length in bytes, a block count and a three-bit boundary code. It then writes a mode word that carries a go bit. One word of `DW` bits moves at a time. In the card-to-memory direction, words taken from the inbound stream are written to memory. In the memory-to-card direction, words read from memory are presented on the outbound stream.

Each moved word advances the working address by one word. When the next address falls on a multiple of the selected boundary (4 KiB shifted left by the boundary code, so 4 KiB up to 512 KiB) and data remains, the engine stops. It raises the boundary status bit and waits. Software resumes the transfer by writing an address; the transfer continues from the address written. When the last block completes, the done status bit is set. An error pulse from the data path aborts the transfer. Status bits are cleared by writing ones to them, and the interrupt line is the OR of the status bits.

Register map, by word index on `reg_addr_i`: 0 is the working address. 1 is the block setup, with byte length in [11:0], boundary code in [14:12] and block count in [31:16]. 2 is the mode word, with enable [0], count enable [1], direction [2] (1 = card to memory), transfer select [4:3] and go [8]. 3 is the status, with done [0], boundary [1] and error [2].

Top module: `sdma_xfer_engine`

## Requirements
- R1: After reset all status bits, the working address, the block count and `irq_o` read as zero, and no memory request or stream handshake is active.
- R2: A go write starts a transfer only when mode bit 0 is set and mode bits [4:3] are 00; with any other select value or with bit 0 clear, no memory request occurs and no status bit is set.
- R3: With direction bit 2 set, inbound stream words are written to memory in arrival order at consecutive word addresses, starting at the programmed address.
- R4: With direction bit 2 clear, memory is read at consecutive word addresses from the programmed address, and the read data appears on the outbound stream in the same order.
- R5: A block holds setup[11:2] words; a length field below one word counts as one word per block.
- R6: When the address after a moved word is a multiple of 4096 shifted left by the boundary code and the transfer is not finished, the engine sets status bit 1 and issues no further memory request.
- R7: Writing register 0 while paused resumes the transfer at the written address, with the remaining words and blocks preserved.
- R8: With count enable set, setup[31:16] drops by one per completed block and the transfer finishes when it reaches zero; with it clear, exactly one block moves and the count is unchanged; a go with count enable set and a count of zero is ignored.
- R9: Status bit 0 is set after the last word of the last block, and a boundary reached at that same word does not set bit 1.
- R10: Writing a 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: `dp_err_i` during an active or paused transfer ends it, sets only status bit 2 in that cycle, and no further memory requests follow.
- R12: While a transfer is active, writes to registers 0, 1 and 2 have no effect.
- R13: `irq_o` is high exactly when some status bit is set.
- R14: A memory request keeps its address, direction and write data until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | RAW | Register word index |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data for `reg_addr_i` |
| irq_o | output | 1 | OR of the status bits |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Request byte address |
| mem_wdata_o | output | DW | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DW | Read data |
| card_in_valid_i | input | 1 | Inbound stream word valid |
| card_in_data_i | input | DW | Inbound stream word |
| card_in_ready_o | output | 1 | Engine takes inbound word |
| card_out_valid_o | output | 1 | Outbound stream word valid |
| card_out_data_o | output | DW | Outbound stream word |
| card_out_ready_i | input | 1 | Sink takes outbound word |
| dp_err_i | input | 1 | Data path error pulse |

## Verification
The word mover is run in both directions. One card-to-memory run uses free grants and checks address order and data order. One memory-to-card run stalls grants and throttles the outbound stream, which shows that requests hold steady under backpressure and that writes made while active are ignored. Boundary runs place the start address two words below a 4 KiB line. With code 0 the engine must pause there and then resume at a new address. With code 1 it must not pause. A separate case puts the boundary exactly on the final word, which tells the done status apart from a pause. Single-block runs with count enable clear, sub-word lengths, zero counts, reserved select values and a mid-transfer error pulse separate the start, count and abort rules from the ordinary completion path.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int REG_ADDR = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_MODE = 2;
  localparam int REG_STS  = 3;

  localparam int STS_DONE = 0;
  localparam int STS_BND  = 1;
  localparam int STS_ERR  = 2;
  localparam int STS_W    = 3;

  localparam int MODE_W   = 5;
  localparam int GO_BIT   = 8;

  typedef struct packed {
    logic [1:0] sel;
    logic       c2m;
    logic       cnt_en;
    logic       dma_en;
  } mode_t;

  typedef enum logic [1:0] {CS_IDLE, CS_RUN, CS_PAUSE} ctl_st_e;
  typedef enum logic [2:0] {MV_IDLE, MV_GET, MV_WR, MV_RD, MV_RWAIT, MV_PUT} mv_st_e;
endpackage

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int RAW    = 4,
  parameter int BSZ_W  = 12,
  parameter int CODE_W = 3,
  parameter int CNT_W  = 16,
  parameter int CNT_LSB = 16,
  localparam int CFG_W = BSZ_W + CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RAW-1:0]    addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic              done_set_i,
  input  logic              bnd_set_i,
  input  logic              err_set_i,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic [CNT_W-1:0]  blk_left_i,
  output logic [DW-1:0]     rdata_o,
  output mode_t             mode_o,
  output logic [BSZ_W-1:0]  bsize_o,
  output logic [CODE_W-1:0] code_o,
  output logic              go_o,
  output logic              irq_o
);
  logic [STS_W-1:0] sts_q, sts_set, sts_clr;
  logic cfg_wr, mode_wr, sts_wr;

  assign cfg_wr  = we_i && addr_i == RAW'(REG_CFG)  && !busy_i;
  assign mode_wr = we_i && addr_i == RAW'(REG_MODE) && !busy_i;
  assign sts_wr  = we_i && addr_i == RAW'(REG_STS);

  assign sts_set = {err_set_i, bnd_set_i, done_set_i};
  assign sts_clr = sts_wr ? wdata_i[STS_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bsize_o <= '0;
      code_o  <= '0;
      mode_o  <= '0;
      go_o    <= 1'b0;
      sts_q   <= '0;
    end else begin
      if (cfg_wr) begin
        bsize_o <= wdata_i[BSZ_W-1:0];
        code_o  <= wdata_i[BSZ_W +: CODE_W];
      end
      if (mode_wr) mode_o <= mode_t'(wdata_i[MODE_W-1:0]);
      go_o  <= mode_wr && wdata_i[GO_BIT];
      sts_q <= sts_set | (sts_q & ~sts_clr);
    end
  end

  assign irq_o = |sts_q;

  always_comb begin
    rdata_o = '0;
    unique case (int'(addr_i))
      REG_ADDR: rdata_o[AW-1:0] = cur_addr_i;
      REG_CFG: begin
        rdata_o[BSZ_W-1:0]       = bsize_o;
        rdata_o[BSZ_W +: CODE_W] = code_o;
        rdata_o[CNT_LSB +: CNT_W] = blk_left_i;
      end
      REG_MODE: rdata_o[MODE_W-1:0] = mode_o;
      REG_STS:  rdata_o[STS_W-1:0]  = sts_q;
      default:  rdata_o = '0;
    endcase
  end

  // error wins over done and boundary in the same cycle
  assert_err_prio_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_set_i |-> !done_set_i && !bnd_set_i);

  assert_w1c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && wdata_i[STS_DONE] && !done_set_i) |=> !sts_q[STS_DONE]);

  assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q[STS_BND] && !(sts_wr && wdata_i[STS_BND])) |=> sts_q[STS_BND]);
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int RAW      = 4,
  parameter int BSZ_W    = 12,
  parameter int CODE_W   = 3,
  parameter int CNT_W    = 16,
  parameter int BND_LOG2 = 12,
  localparam int BPW     = DW / 8,
  localparam int WSH     = $clog2(BPW),
  localparam int WCW     = BSZ_W - WSH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [RAW-1:0]    reg_addr_i,
  input  logic [AW-1:0]     addr_wdata_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              go_i,
  input  mode_t             mode_i,
  input  logic [BSZ_W-1:0]  bsize_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              word_done_i,
  input  logic              err_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              paused_o,
  output logic [AW-1:0]     addr_o,
  output logic [CNT_W-1:0]  blk_left_o,
  output logic              done_set_o,
  output logic              bnd_set_o,
  output logic              err_set_o
);
  ctl_st_e st_q, st_d;
  logic [AW-1:0]    addr_q, addr_d, addr_inc, bnd_mask;
  logic [WCW-1:0]   wl_q, wl_d, wpb;
  logic [CNT_W-1:0] bl_q, bl_d;
  logic addr_wr, cnt_wr, start, fin;

  assign wpb      = (bsize_i[BSZ_W-1:WSH] == '0) ? WCW'(1) : bsize_i[BSZ_W-1:WSH];
  assign bnd_mask = (AW'(1) << (BND_LOG2 + int'(code_i))) - AW'(1);
  assign addr_inc = addr_q + AW'(BPW);
  assign addr_wr  = reg_we_i && reg_addr_i == RAW'(REG_ADDR);
  assign cnt_wr   = reg_we_i && reg_addr_i == RAW'(REG_CFG) && st_q == CS_IDLE;
  assign start    = go_i && mode_i.dma_en && mode_i.sel == 2'b00 &&
                    !(mode_i.cnt_en && bl_q == '0);

  always_comb begin
    st_d = st_q;
    addr_d = addr_q;
    wl_d = wl_q;
    bl_d = bl_q;
    done_set_o = 1'b0;
    bnd_set_o = 1'b0;
    fin = 1'b0;
    unique case (st_q)
      CS_IDLE: begin
        if (addr_wr) addr_d = addr_wdata_i;
        if (cnt_wr)  bl_d = cnt_wdata_i;
        if (start) begin
          st_d = CS_RUN;
          wl_d = wpb;
        end
      end
      CS_RUN: begin
        if (err_i) begin
          st_d = CS_IDLE;
        end else if (word_done_i) begin
          addr_d = addr_inc;
          if (wl_q == WCW'(1)) begin
            wl_d = wpb;
            if (mode_i.cnt_en) bl_d = bl_q - CNT_W'(1);
            fin = !mode_i.cnt_en || bl_q == CNT_W'(1);
          end else begin
            wl_d = wl_q - WCW'(1);
          end
          if (fin) begin
            st_d = CS_IDLE;
            done_set_o = 1'b1;
          end else if ((addr_inc & bnd_mask) == '0) begin
            st_d = CS_PAUSE;
            bnd_set_o = 1'b1;
          end
        end
      end
      CS_PAUSE: begin
        if (err_i) begin
          st_d = CS_IDLE;
        end else if (addr_wr) begin
          addr_d = addr_wdata_i;
          st_d = CS_RUN;
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CS_IDLE;
      addr_q <= '0;
      wl_q   <= '0;
      bl_q   <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      wl_q   <= wl_d;
      bl_q   <= bl_d;
    end
  end

  assign err_set_o  = err_i && st_q != CS_IDLE;
  assign run_o      = st_q == CS_RUN;
  assign busy_o     = st_q != CS_IDLE;
  assign paused_o   = st_q == CS_PAUSE;
  assign addr_o     = addr_q;
  assign blk_left_o = bl_q;

  assert_bnd_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CS_PAUSE && $past(st_q) == CS_RUN) |-> (addr_q & bnd_mask) == '0);

  assert_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CS_RUN && !mode_i.cnt_en) |=> $stable(bl_q));

  assert_addr_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CS_RUN && !word_done_i) |=> $stable(addr_q));
endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
  import sdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          c2m_i,
  input  logic [AW-1:0] addr_i,
  input  logic          flush_i,
  output logic          word_done_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic          mem_rvalid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  input  logic          out_ready_i
);
  mv_st_e st_q, st_d;
  logic [DW-1:0] buf_q;
  logic load_in, load_rd;

  assign in_ready_o  = st_q == MV_GET;
  assign out_valid_o = st_q == MV_PUT;
  assign out_data_o  = buf_q;
  assign mem_req_o   = st_q == MV_WR || st_q == MV_RD;
  assign mem_we_o    = st_q == MV_WR;
  assign mem_addr_o  = addr_i;
  assign mem_wdata_o = buf_q;
  assign word_done_o = (st_q == MV_WR && mem_gnt_i) || (st_q == MV_PUT && out_ready_i);
  assign load_in     = st_q == MV_GET && in_valid_i;
  assign load_rd     = st_q == MV_RWAIT && mem_rvalid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      MV_IDLE:  if (run_i) st_d = c2m_i ? MV_GET : MV_RD;
      MV_GET:   if (in_valid_i) st_d = MV_WR;
      MV_WR:    if (mem_gnt_i) st_d = MV_IDLE;
      MV_RD:    if (mem_gnt_i) st_d = MV_RWAIT;
      MV_RWAIT: if (mem_rvalid_i) st_d = MV_PUT;
      MV_PUT:   if (out_ready_i) st_d = MV_IDLE;
      default:  st_d = MV_IDLE;
    endcase
    if (flush_i) st_d = MV_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= MV_IDLE;
      buf_q <= '0;
    end else begin
      st_q <= st_d;
      if (load_in)      buf_q <= in_data_i;
      else if (load_rd) buf_q <= mem_rdata_i;
    end
  end

  assert_req_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    (mem_req_o && !mem_gnt_i) |=> mem_req_o && $stable(mem_addr_o) &&
    $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_out_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni || flush_i)
    (out_valid_o && !out_ready_i) |=> out_valid_o && $stable(out_data_o));
endmodule

// File: rtl/sdma_xfer_engine.sv
module sdma_xfer_engine
  import sdma_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int RAW      = 4,
  parameter int BSZ_W    = 12,
  parameter int CODE_W   = 3,
  parameter int CNT_W    = 16,
  parameter int CNT_LSB  = 16,
  parameter int BND_LOG2 = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           reg_we_i,
  input  logic [RAW-1:0] reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic           irq_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic           mem_gnt_i,
  input  logic           mem_rvalid_i,
  input  logic [DW-1:0]  mem_rdata_i,
  input  logic           card_in_valid_i,
  input  logic [DW-1:0]  card_in_data_i,
  output logic           card_in_ready_o,
  output logic           card_out_valid_o,
  output logic [DW-1:0]  card_out_data_o,
  input  logic           card_out_ready_i,
  input  logic           dp_err_i
);
  localparam int CFG_W = BSZ_W + CODE_W;

  mode_t             mode;
  logic [BSZ_W-1:0]  bsize;
  logic [CODE_W-1:0] code;
  logic [AW-1:0]     cur_addr;
  logic [CNT_W-1:0]  blk_left;
  logic go, run, busy, paused, word_done, done_set, bnd_set, err_set;
  logic spare_unused;

  assign spare_unused = ^reg_wdata_i[CNT_LSB-1:CFG_W];

  sdma_regs #(
    .DW(DW), .AW(AW), .RAW(RAW), .BSZ_W(BSZ_W), .CODE_W(CODE_W),
    .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i[CFG_W-1:0]),
    .busy_i(busy), .done_set_i(done_set), .bnd_set_i(bnd_set), .err_set_i(err_set),
    .cur_addr_i(cur_addr), .blk_left_i(blk_left),
    .rdata_o(reg_rdata_o), .mode_o(mode), .bsize_o(bsize), .code_o(code),
    .go_o(go), .irq_o(irq_o)
  );

  sdma_ctrl #(
    .AW(AW), .DW(DW), .RAW(RAW), .BSZ_W(BSZ_W), .CODE_W(CODE_W),
    .CNT_W(CNT_W), .BND_LOG2(BND_LOG2)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .reg_we_i, .reg_addr_i,
    .addr_wdata_i(reg_wdata_i[AW-1:0]), .cnt_wdata_i(reg_wdata_i[CNT_LSB +: CNT_W]),
    .go_i(go), .mode_i(mode), .bsize_i(bsize), .code_i(code),
    .word_done_i(word_done), .err_i(dp_err_i),
    .run_o(run), .busy_o(busy), .paused_o(paused), .addr_o(cur_addr),
    .blk_left_o(blk_left), .done_set_o(done_set), .bnd_set_o(bnd_set),
    .err_set_o(err_set)
  );

  sdma_mover #(.AW(AW), .DW(DW)) u_mover (
    .clk_i, .rst_ni,
    .run_i(run), .c2m_i(mode.c2m), .addr_i(cur_addr), .flush_i(dp_err_i),
    .word_done_o(word_done),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .in_valid_i(card_in_valid_i), .in_data_i(card_in_data_i), .in_ready_o(card_in_ready_o),
    .out_valid_o(card_out_valid_o), .out_data_o(card_out_data_o), .out_ready_i(card_out_ready_i)
  );

  assert_pause_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused |-> !mem_req_o);

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> !mem_req_o || busy);
endmodule

// File: tb/sim_sdma_xfer_engine.sv
`timescale 1ns/1ps
module sim_sdma_xfer_engine;
  localparam logic [31:0] KEY = 32'hC3C3_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we, mem_gnt, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic in_ready, out_valid, out_ready, dp_err = 1'b0;
  logic [31:0] out_data, in_cnt = '0;
  logic stall_all = 1'b0, out_slow = 1'b0, tg = 1'b0;

  int checks = 0, errors = 0;
  logic [31:0] wr_addr [0:255];
  logic [31:0] wr_data [0:255];
  logic [31:0] rd_log  [0:255];
  int wr_n = 0, rd_n = 0;

  assign mem_gnt   = mem_req && !stall_all;
  assign out_ready = out_slow ? tg : 1'b1;

  sdma_xfer_engine u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .card_in_valid_i(1'b1), .card_in_data_i(in_cnt), .card_in_ready_o(in_ready),
    .card_out_valid_o(out_valid), .card_out_data_o(out_data), .card_out_ready_i(out_ready),
    .dp_err_i(dp_err)
  );

  always @(posedge clk) begin
    tg <= ~tg;
    mem_rvalid <= 1'b0;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        wr_addr[wr_n[7:0]] <= mem_addr;
        wr_data[wr_n[7:0]] <= mem_wdata;
        wr_n <= wr_n + 1;
      end else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_addr ^ KEY;
      end
    end
    if (in_ready) in_cnt <= in_cnt + 1;
    if (out_valid && out_ready) begin
      rd_log[rd_n[7:0]] <= out_data;
      rd_n <= rd_n + 1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rreg(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] cfg(input int cnt, input int code, input int bs);
    return (32'(cnt) << 16) | (32'(code) << 12) | 32'(bs);
  endfunction

  task automatic wait_irq(input int lim);
    for (int i = 0; i < lim && !irq; i++) @(negedge clk);
  endtask

  task automatic idle_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_writes(input string rq, input int base, input int first, input int n,
                            input logic [31:0] a0, input logic [31:0] d0);
    for (int k = 0; k < n; k++) begin
      chk(rq, wr_addr[base + first + k], a0 + 32'(4 * k));
      chk(rq, wr_data[base + first + k], d0 + 32'(first + k));
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rreg(3, v); chk("R1 status", v, 0);
    rreg(0, v); chk("R1 addr", v, 0);
    rreg(1, v); chk("R1 count", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 req", {31'b0, mem_req}, 0);
    chk("R1 in_ready", {31'b0, in_ready}, 0);
  endtask

  task automatic t_c2m_multi;
    logic [31:0] v, d0;
    int b;
    b = wr_n; d0 = in_cnt;
    wreg(0, 32'h1000); wreg(1, cfg(3, 7, 16)); wreg(2, 32'h107);
    wait_irq(2000);
    chk("R3 count", 32'(wr_n - b), 12);
    chk_writes("R3 order", b, 0, 12, 32'h1000, d0);
    rreg(3, v); chk("R9 done", v, 1);
    rreg(1, v); chk("R8 count zero", v[31:16], 0);
    chk("R13 irq set", {31'b0, irq}, 1);
    wreg(3, 0);
    rreg(3, v); chk("R10 write zero keeps", v, 1);
    wreg(3, 1);
    rreg(3, v); chk("R10 w1c", v, 0);
    chk("R13 irq clear", {31'b0, irq}, 0);
  endtask

  task automatic t_m2c_stall;
    logic [31:0] v;
    int r;
    r = rd_n;
    stall_all = 1'b1;
    wreg(0, 32'h5000); wreg(1, cfg(2, 7, 8)); wreg(2, 32'h103);
    idle_n(10);
    chk("R14 req held", {31'b0, mem_req}, 1);
    chk("R14 addr held", mem_addr, 32'h5000);
    chk("R14 dir held", {31'b0, mem_we}, 0);
    wreg(0, 32'h9000); wreg(1, cfg(9, 7, 4)); wreg(2, 32'h107);
    rreg(0, v); chk("R12 addr ignored", v, 32'h5000);
    rreg(1, v); chk("R12 cfg ignored", v, cfg(2, 7, 8));
    out_slow = 1'b1;
    stall_all = 1'b0;
    wait_irq(2000);
    chk("R4 count", 32'(rd_n - r), 4);
    for (int k = 0; k < 4; k++)
      chk("R4 data", rd_log[r + k], (32'h5000 + 32'(4 * k)) ^ KEY);
    rreg(3, v); chk("R9 done m2c", v, 1);
    rreg(1, v); chk("R12 count after", v[31:16], 0);
    out_slow = 1'b0;
    wreg(3, 7);
  endtask

  task automatic t_boundary_resume;
    logic [31:0] v, d0;
    int b;
    b = wr_n; d0 = in_cnt;
    wreg(0, 32'h0FF8); wreg(1, cfg(2, 0, 16)); wreg(2, 32'h107);
    wait_irq(2000);
    idle_n(20);
    chk("R6 words before pause", 32'(wr_n - b), 2);
    chk("R6 no request", {31'b0, mem_req}, 0);
    rreg(3, v); chk("R6 boundary bit", v, 2);
    rreg(0, v); chk("R6 pause addr", v, 32'h1000);
    rreg(1, v); chk("R8 count at pause", v[31:16], 2);
    chk_writes("R6 pre", b, 0, 2, 32'h0FF8, d0);
    wreg(3, 2);
    wreg(0, 32'h3000);
    wait_irq(2000);
    chk("R7 total", 32'(wr_n - b), 8);
    chk_writes("R7 resumed", b, 2, 6, 32'h3000, d0);
    rreg(3, v); chk("R7 done", v, 1);
    rreg(1, v); chk("R8 count end", v[31:16], 0);
    wreg(3, 7);
  endtask

  task automatic t_boundary_at_end;
    logic [31:0] v;
    int b;
    b = wr_n;
    wreg(0, 32'h1FF0); wreg(1, cfg(1, 0, 16)); wreg(2, 32'h107);
    wait_irq(2000);
    idle_n(4);
    chk("R9 words", 32'(wr_n - b), 4);
    rreg(3, v); chk("R9 done without boundary", v, 1);
    wreg(3, 7);
  endtask

  task automatic t_code_one;
    logic [31:0] v;
    int b;
    b = wr_n;
    wreg(0, 32'h0FF8); wreg(1, cfg(1, 1, 16)); wreg(2, 32'h107);
    wait_irq(2000);
    idle_n(4);
    chk("R6 8K no pause words", 32'(wr_n - b), 4);
    chk("R6 8K crosses 4K", wr_addr[b + 2], 32'h1000);
    rreg(3, v); chk("R6 8K status", v, 1);
    wreg(3, 7);
  endtask

  task automatic t_no_dma;
    logic [31:0] v;
    int b;
    b = wr_n;
    wreg(0, 32'h0800); wreg(1, cfg(2, 7, 8)); wreg(2, 32'h117);
    idle_n(40);
    chk("R2 select ten", 32'(wr_n - b), 0);
    rreg(3, v); chk("R2 select status", v, 0);
    wreg(2, 32'h106);
    idle_n(40);
    chk("R2 disabled", 32'(wr_n - b), 0);
    rreg(3, v); chk("R2 disabled status", v, 0);
    wreg(1, cfg(0, 7, 16)); wreg(2, 32'h107);
    idle_n(40);
    chk("R8 zero count ignored", 32'(wr_n - b), 0);
    rreg(3, v); chk("R8 zero count status", v, 0);
  endtask

  task automatic t_single_block;
    logic [31:0] v;
    int b;
    b = wr_n;
    wreg(0, 32'h0600); wreg(1, cfg(5, 7, 8)); wreg(2, 32'h105);
    wait_irq(2000);
    idle_n(4);
    chk("R8 one block words", 32'(wr_n - b), 2);
    rreg(1, v); chk("R8 count unchanged", v[31:16], 5);
    rreg(3, v); chk("R8 done", v, 1);
    wreg(3, 7);
  endtask

  task automatic t_small_block;
    logic [31:0] v, d0;
    int b;
    b = wr_n; d0 = in_cnt;
    wreg(0, 32'h0400); wreg(1, cfg(3, 7, 2)); wreg(2, 32'h107);
    wait_irq(2000);
    idle_n(4);
    chk("R5 words", 32'(wr_n - b), 3);
    chk_writes("R5 addr", b, 0, 3, 32'h0400, d0);
    rreg(3, v); chk("R5 done", v, 1);
    wreg(3, 7);
  endtask

  task automatic t_error;
    logic [31:0] v;
    int b, n;
    b = wr_n;
    wreg(0, 32'h8000); wreg(1, cfg(4, 7, 16)); wreg(2, 32'h107);
    for (int i = 0; i < 500 && (wr_n - b) < 3; i++) @(negedge clk);
    dp_err = 1'b1;
    @(negedge clk);
    dp_err = 1'b0;
    n = wr_n;
    idle_n(30);
    chk("R11 stopped", 32'(wr_n), 32'(n));
    chk("R11 no request", {31'b0, mem_req}, 0);
    rreg(3, v); chk("R11 error only", v, 4);
    wreg(3, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_n(2);
    t_reset();
    t_c2m_multi();
    t_m2c_stall();
    t_boundary_resume();
    t_boundary_at_end();
    t_code_one();
    t_no_dma();
    t_single_block();
    t_small_block();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule